// File: doc/BRIEF.md
# Glitch-Free Clock Bank Shutdown Controller

This block derives three groups of clock outputs (A, B and C) from one fast master clock. Each group has its own free-running divide-by-2H counter, so its output has a 50% duty cycle and a period of 2H master cycles. Every group drives a small bank of identical copies. A 2-bit shutdown code, which may change at any time and is not tied to the master clock, selects which groups are held off.

The code passes through a two-stage synchronizer. The decoded enable for a group is then updated only on master edges where that group's divided clock is low and will still be low after the edge. As a result a stopped output never shows a shortened high pulse, and a started output never begins part-way through a high phase. The dividers keep counting while their outputs are held off. A group that is switched back on therefore rejoins in exact phase with the groups that kept running. Group C cannot be stopped by any code.

Top module: `clk_bank_gate`

## Requirements
- R1: The code selects the stopped groups: 2'b00 stops none, 2'b01 stops group A, 2'b10 stops group B, 2'b11 stops groups A and B.
- R2: Each code bit passes through two reset-cleared flops. A code change therefore cannot alter any output before the third master rising edge that follows it.
- R3: Every high pulse on a group output lasts exactly H master cycles for that group. Defaults: H is 2 for A, 3 for B and 5 for C.
- R4: A group output rises only on the master edge where a free-running divide-by-2H reference, started with the block, enters its high phase. This also holds for the first pulse after re-enabling.
- R5: A stopped group's outputs stay at logic low.
- R6: While rstN is low, all outputs are low. Each divider is reset to the first count of its low phase, so group g first rises on the H(g)-th master edge after reset is released.
- R7: Group C runs under every code.
- R8: After the code returns to one that enables a group, the group pulses again within 4H+6 master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shutCode | input | 2 | Asynchronous shutdown code |
| clkOutA | output | OUTS | Gated copies of group A clock |
| clkOutB | output | OUTS | Gated copies of group B clock |
| clkOutC | output | OUTS | Copies of group C clock (never stopped) |

## Verification
Two events can land in the same master cycle: a synchronized code change reaching the enable logic, and a group's divided clock rising or falling. The bench triggers this by sweeping the cycle offset at which the code toggles between all-on and A+B-off across every phase position of the divider periods. A continuous monitor judges each offset: every rising edge must line up with a bench reference divider, and every high run must last exactly H cycles. A mistimed enable update would appear as a shifted rise or a short pulse.

// File: rtl/clk_bank_pkg.sv
package clk_bank_pkg;
  localparam int NGRP = 3;
  localparam int GRP_A = 0;
  localparam int GRP_B = 1;
  localparam int GRP_C = 2;

  typedef enum logic [1:0] {
    CODE_ALL_ON = 2'b00,
    CODE_A_OFF  = 2'b01,
    CODE_B_OFF  = 2'b10,
    CODE_AB_OFF = 2'b11
  } shutCode_e;

  typedef struct packed {
    logic [NGRP-1:0] grpEn;
  } ctrlStrb_t;
endpackage

// File: rtl/cbg_ctrl.sv
module cbg_ctrl
  import clk_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      shutCode,
  input  logic [NGRP-1:0] safe,
  output ctrlStrb_t       strb
);
  logic [1:0]      syncQ1, syncQ2;
  logic [NGRP-1:0] wantOn;
  logic [NGRP-1:0] enQ;

  // two-stage synchronizer, reset to the all-on code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= CODE_ALL_ON;
      syncQ2 <= CODE_ALL_ON;
    end else begin
      syncQ1 <= shutCode;
      syncQ2 <= syncQ1;
    end
  end

  always_comb begin
    wantOn = '1;
    unique case (shutCode_e'(syncQ2))
      CODE_ALL_ON: wantOn = '1;
      CODE_A_OFF:  wantOn[GRP_A] = 1'b0;
      CODE_B_OFF:  wantOn[GRP_B] = 1'b0;
      CODE_AB_OFF: begin
        wantOn[GRP_A] = 1'b0;
        wantOn[GRP_B] = 1'b0;
      end
      default:     wantOn = '1;
    endcase
  end

  // enables move only inside a group's stable low window
  for (genvar g = 0; g < NGRP; g++) begin : g_en
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        enQ[g] <= 1'b1;
      else if (safe[g]) enQ[g] <= wantOn[g];
    end
  end

  assign strb.grpEn = enQ;
endmodule

// File: rtl/cbg_divider.sv
module cbg_divider #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic divClk,
  output logic safe
);
  localparam int PERIOD = 2 * HALF;
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= HALF_C;
    else if (cnt == LAST_C) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign divClk = (cnt < HALF_C);
  // low now and still low after the next edge
  assign safe = (cnt >= HALF_C) && (cnt != LAST_C);
endmodule

// File: rtl/cbg_dpath.sv
module cbg_dpath
  import clk_bank_pkg::*;
#(
  parameter int HALF_A = 2,
  parameter int HALF_B = 3,
  parameter int HALF_C = 5,
  parameter int OUTS   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  output logic [NGRP-1:0] divClk,
  output logic [NGRP-1:0] safe,
  output logic [OUTS-1:0] clkOutA,
  output logic [OUTS-1:0] clkOutB,
  output logic [OUTS-1:0] clkOutC
);
  for (genvar g = 0; g < NGRP; g++) begin : g_div
    localparam int H = (g == GRP_A) ? HALF_A : (g == GRP_B) ? HALF_B : HALF_C;
    cbg_divider #(.HALF(H)) div_i (
      .clk    (clk),
      .rstN   (rstN),
      .divClk (divClk[g]),
      .safe   (safe[g])
    );
  end

  logic [NGRP-1:0] gated;
  assign gated = divClk & strb.grpEn;

  assign clkOutA = {OUTS{gated[GRP_A]}};
  assign clkOutB = {OUTS{gated[GRP_B]}};
  assign clkOutC = {OUTS{gated[GRP_C]}};
endmodule

// File: rtl/clk_bank_gate.sv
module clk_bank_gate
  import clk_bank_pkg::*;
#(
  parameter int HALF_A = 2,
  parameter int HALF_B = 3,
  parameter int HALF_C = 5,
  parameter int OUTS   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      shutCode,
  output logic [OUTS-1:0] clkOutA,
  output logic [OUTS-1:0] clkOutB,
  output logic [OUTS-1:0] clkOutC
);
  ctrlStrb_t       strb;
  logic [NGRP-1:0] divClk;
  logic [NGRP-1:0] safe;

  cbg_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .shutCode (shutCode),
    .safe     (safe),
    .strb     (strb)
  );

  cbg_dpath #(
    .HALF_A (HALF_A),
    .HALF_B (HALF_B),
    .HALF_C (HALF_C),
    .OUTS   (OUTS)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .divClk  (divClk),
    .safe    (safe),
    .clkOutA (clkOutA),
    .clkOutB (clkOutB),
    .clkOutC (clkOutC)
  );
endmodule

// File: rtl/cbg_chk.sv
module cbg_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] shutCode,
  input logic [2:0] divClk,
  input logic [2:0] grpEn,
  input logic [2:0] safe,
  input logic       outA0,
  input logic       outB0
);
  // R4
  rise_align_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outA0) |-> $rose(divClk[0]));

  // R3
  fall_align_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outB0) |-> $fell(divClk[1]));

  // R3
  en_change_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grpEn[0] != $past(grpEn[0])) |-> (!divClk[0] && !$past(divClk[0])));

  // R1
  decode_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(shutCode, 2) == 2'b11) && safe[0]) |=> !grpEn[0]);

  // R1
  decode_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(shutCode, 2) == 2'b00) && safe[1]) |=> grpEn[1]);
endmodule

bind clk_bank_gate cbg_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .shutCode (shutCode),
  .divClk   (divClk),
  .grpEn    (strb.grpEn),
  .safe     (safe),
  .outA0    (clkOutA[0]),
  .outB0    (clkOutB[0])
);

// File: tb/clk_bank_gate_tb_top.sv
`timescale 1ns/1ps
module clk_bank_gate_tb_top;
  localparam int HA = 2, HB = 3, HC = 5, OUTS = 2;
  localparam int HMAX = 5;
  localparam int SETTLE = 4 * HMAX + 6;
  localparam int HV [3] = '{HA, HB, HC};

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] shutCode;
  logic [OUTS-1:0] clkOutA, clkOutB, clkOutC;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clk_bank_gate #(.HALF_A(HA), .HALF_B(HB), .HALF_C(HC), .OUTS(OUTS)) dut_i (
    .clk(clk), .rstN(rstN), .shutCode(shutCode),
    .clkOutA(clkOutA), .clkOutB(clkOutB), .clkOutC(clkOutC)
  );

  // free-running reference dividers (R4, R6)
  int refCnt [3];
  always @(posedge clk) begin
    for (int g = 0; g < 3; g++) begin
      if (!rstN) refCnt[g] <= HV[g];
      else refCnt[g] <= (refCnt[g] == 2 * HV[g] - 1) ? 0 : refCnt[g] + 1;
    end
  end

  function automatic logic [OUTS-1:0] grpOut(int g);
    return (g == 0) ? clkOutA : (g == 1) ? clkOutB : clkOutC;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // continuous pulse monitor
  bit prevHi [3];
  int runLen [3];
  bit sawHi [3];
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      for (int g = 0; g < 3; g++) begin
        logic [OUTS-1:0] o;
        o = grpOut(g);
        if (o[0]) sawHi[g] = 1;
        if (o[0] && !prevHi[g]) begin
          // R4 rising edge aligned to reference
          check(refCnt[g] == 0, "R4 rise phase", refCnt[g], 0);
          check(o == '1, "R4 copies equal", int'(o), (1 << OUTS) - 1);
          runLen[g] = 1;
        end else if (o[0]) begin
          runLen[g]++;
        end else if (prevHi[g]) begin
          // R3 full pulse width
          check(runLen[g] == HV[g], "R3 pulse width", runLen[g], HV[g]);
        end
        prevHi[g] = o[0];
      end
    end else begin
      for (int g = 0; g < 3; g++) begin prevHi[g] = 0; runLen[g] = 0; end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearSaw();
    for (int g = 0; g < 3; g++) sawHi[g] = 0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    shutCode = 2'b00;
    cyc(4);
    check({clkOutA, clkOutB, clkOutC} == '0, "R6 low in reset",
          int'({clkOutA, clkOutB, clkOutC}), 0);
    rstN = 1'b1;
    // first rise of A at the HA-th edge after release
    cyc(HA - 1);
    check(clkOutA[0] == 1'b0, "R6 A before first rise", clkOutA[0], 0);
    cyc(1);
    check(clkOutA[0] == 1'b1, "R6 A first rise", clkOutA[0], 1);
    cyc(HC - HA - 1);
    check(clkOutC[0] == 1'b0, "R6 C before first rise", clkOutC[0], 0);
    cyc(1);
    check(clkOutC[0] == 1'b1, "R6 C first rise", clkOutC[0], 1);
  endtask

  // R1 R5 R7 mapping of each code
  task automatic t_mapping(logic [1:0] code);
    bit expOn [3];
    expOn[0] = !code[0];
    expOn[1] = !code[1];
    expOn[2] = 1;
    shutCode = code;
    cyc(SETTLE);
    clearSaw();
    for (int i = 0; i < 4 * HMAX; i++) begin
      cyc(1);
      if (!expOn[0]) check(clkOutA == '0, "R5 A held low", int'(clkOutA), 0);
      if (!expOn[1]) check(clkOutB == '0, "R5 B held low", int'(clkOutB), 0);
    end
    check(sawHi[0] == expOn[0], "R1 group A state", sawHi[0], expOn[0]);
    check(sawHi[1] == expOn[1], "R1 group B state", sawHi[1], expOn[1]);
    check(sawHi[2] == 1'b1, "R7 group C runs", sawHi[2], 1);
  endtask

  // R2: code change cannot act before the third edge
  task automatic t_sync();
    shutCode = 2'b00;
    cyc(SETTLE);
    while (refCnt[0] != HA) cyc(1);
    clearSaw();
    shutCode = 2'b01;
    cyc(2 * HA);
    check(sawHi[0] == 1'b1, "R2 pulse after late stop", sawHi[0], 1);
    cyc(SETTLE);
    clearSaw();
    cyc(4 * HMAX);
    check(sawHi[0] == 1'b0, "R2 A stops afterwards", sawHi[0], 0);
  endtask

  // R3 R4 R8 sweep code toggles across all phase offsets
  task automatic t_sweep();
    for (int off = 0; off < 2 * HA * HB * HC / 5 + 2; off++) begin
      shutCode = 2'b00;
      cyc(SETTLE + off);
      shutCode = 2'b11;
      cyc(SETTLE);
      clearSaw();
      shutCode = 2'b00;
      cyc(SETTLE);
      check(sawHi[0] && sawHi[1], "R8 resume after enable",
            int'(sawHi[0]) + int'(sawHi[1]), 2);
    end
  endtask

  // one-cycle code glitch must leave clean pulses and all running
  task automatic t_glitch();
    for (int off = 0; off < 6; off++) begin
      shutCode = 2'b00;
      cyc(SETTLE + off);
      shutCode = 2'b11;
      cyc(1);
      shutCode = 2'b00;
      cyc(SETTLE);
      clearSaw();
      cyc(4 * HMAX);
      check(sawHi[0] && sawHi[1] && sawHi[2], "R8 running after glitch",
            int'(sawHi[0]) + int'(sawHi[1]) + int'(sawHi[2]), 3);
    end
  endtask

  initial begin
    t_reset();
    t_mapping(2'b00);
    t_mapping(2'b01);
    t_mapping(2'b10);
    t_mapping(2'b11);
    t_mapping(2'b00);
    t_sync();
    t_sweep();
    t_glitch();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule